// File: doc/BRIEF.md
# Alarm status and interrupt controller

This block collects the alarms of seven line channels and one global alarm, holds them in read-only status registers and combines them into one active-high interrupt. Each channel has a loss-of-signal input from its receiver, and its transmit clock is monitored. The reference clock is monitored globally. A clock counts as lost when a free-running detection clock sees no edge of it for a set number of cycles. A clock-loss alarm then stays up for a minimum hold time, 126 microseconds by default at a 50 MHz detection clock, even if the clock comes back sooner.

Software reads the status through a small register port and programs the masks. Three masks are available: one per alarm bit, one per channel that silences both of that channel's alarms, and one for the reference alarm. The masks only gate the interrupt. The status bits and the per-channel loss-of-signal pins always show the real alarm state. A lost reference clock raises every channel's loss-of-signal bit together with the global bit. A lost transmit clock forces that channel's transmit line outputs to zero.

Top module: `alm_irq_ctrl`

## Requirements
- R1: `irq` is high exactly when, one cycle earlier, some alarm was set with all of its gating masks low. Loss of signal and transmit-clock loss are gated by their own bit and by the channel bit. Reference loss is gated by its own bit. A mask write therefore changes `irq` one cycle after the write edge.
- R2: After reset, address 2 reads 0xFE, address 3 reads 0xFF and address 4 reads 0xFE, and `irq` is low.
- R3: The status bits and `los_pin` follow the alarms whatever the mask settings are.
- R4: A monitored clock that shows no edge for `LOSS_CYC` detection cycles raises its alarm. Once the clock returns, the alarm stays high for at least `HOLD_CYC` further cycles and then clears.
- R5: While the reference clock is lost, address 1 bit 0 is set, and every loss-of-signal bit and every `los_pin` is high.
- R6: Address 4 holds the channel masks, with bit i+1 for channel i and reset value 1. A set channel mask keeps both alarms of that channel off `irq`.
- R7: `tx_zero[i]` is high while the transmit-clock alarm of channel i is set.
- R8: Writes to addresses 0 and 1 have no effect.
- R9: `rx_keep` is bit 0 of address 2. It resets to 0 and can be read back.
- R10: Address 0 bit i+1 is the loss-of-signal alarm of channel i, and bit 0 reads 0. Address 1 bit i+1 is the transmit-clock alarm of channel i, and bit 0 is the reference alarm. Address 2 bits 7:1 mask loss of signal per channel. Address 3 bits 7:1 mask transmit-clock loss per channel, and bit 0 masks the reference alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running detection and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_clk_in | input | NCH | Per-channel transmit clocks under watch |
| ref_clk_in | input | 1 | Reference clock under watch |
| los_in | input | NCH | Per-channel loss-of-signal from the receivers |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata | input | NCH+1 | Write data |
| reg_rdata | output | NCH+1 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Registered active-high interrupt |
| los_pin | output | NCH | Per-channel loss-of-signal alarm, never masked |
| tx_zero | output | NCH | Force the channel's transmit outputs to zero |
| rx_keep | output | 1 | Receive-data-enable control bit |

## Verification
A mask write and an alarm can both move `irq` in the same cycle. The bench raises a loss-of-signal alarm, then clears the masks for it. It checks that `irq` keeps its old value at the sample right after the write edge and takes the new one a cycle later. Reference loss and per-channel loss of signal also fall together. With a reference clock stopped, the bench checks that every loss-of-signal bit rises while only the reference mask decides the interrupt. It then checks that the global alarm outlives the clock's return by the hold time.

// File: rtl/alm_pkg.sv
// Shared register addresses for the alarm controller.
package alm_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_LOS_STAT = 3'd0;   // loss-of-signal status
    localparam logic [ADDR_W-1:0] A_CLK_STAT = 3'd1;   // clock-loss status
    localparam logic [ADDR_W-1:0] A_LOS_MSK  = 3'd2;   // loss-of-signal masks + rx_keep
    localparam logic [ADDR_W-1:0] A_CLK_MSK  = 3'd3;   // clock-loss masks
    localparam logic [ADDR_W-1:0] A_CH_MSK   = 3'd4;   // per-channel masks
endpackage

// File: rtl/alm_clk_mon.sv
// Clock-loss monitor. It syncs a watched clock into clk with two flops and
// detects its toggles. The alarm rises after LOSS_CYC cycles with no edge and
// is held for HOLD_CYC cycles after the last lost cycle.
// Assumes the watched clock runs well below half of clk.
module alm_clk_mon #(
    parameter int LOSS_CYC = 8,
    parameter int HOLD_CYC = 6300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic alarm
);
    localparam int GW = $clog2(LOSS_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [GW-1:0] LOSS_V = GW'(LOSS_CYC);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

    logic [2:0]    sync_q;
    logic [GW-1:0] gap_q;
    logic [HW-1:0] hold_q;
    logic          seen_edge;
    logic          lost;

    // Two-flop synchronizer plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], mon_clk};
    end

    assign seen_edge = sync_q[2] ^ sync_q[1];
    assign lost      = (gap_q == LOSS_V);

    // Count detection cycles since the last edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || seen_edge) gap_q <= '0;
        else if (!lost)          gap_q <= gap_q + 1'b1;
    end

    // Reloadable down-counter that stretches the alarm.
    always_ff @(posedge clk) begin
        if (!rst_n)           hold_q <= '0;
        else if (lost)        hold_q <= HOLD_V;
        else if (hold_q != 0) hold_q <= hold_q - 1'b1;
    end

    assign alarm = lost || (hold_q != '0);
endmodule

// File: rtl/alm_regs.sv
// Mask registers and the read multiplexer. The status addresses are
// read-only and writes to them are dropped. Reads are combinational.
module alm_regs
    import alm_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [NCH:0]      wdata,
    input  logic [NCH-1:0]    los_stat,
    input  logic [NCH-1:0]    clk_stat,
    input  logic              ref_stat,
    output logic [NCH:0]      rdata,
    output logic [NCH-1:0]    m_los,
    output logic [NCH-1:0]    m_clk,
    output logic              m_ref,
    output logic [NCH-1:0]    m_ch,
    output logic              rx_keep
);
    // Mask writes; every mask resets to 1 and rx_keep resets to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_los   <= '1;
            m_clk   <= '1;
            m_ref   <= 1'b1;
            m_ch    <= '1;
            rx_keep <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_LOS_MSK: {m_los, rx_keep} <= wdata;
                A_CLK_MSK: {m_clk, m_ref}   <= wdata;
                A_CH_MSK:  m_ch             <= wdata[NCH:1];
                default:   ;
            endcase
        end
    end

    // Read-back selection.
    always_comb begin
        case (addr)
            A_LOS_STAT: rdata = {los_stat, 1'b0};
            A_CLK_STAT: rdata = {clk_stat, ref_stat};
            A_LOS_MSK:  rdata = {m_los, rx_keep};
            A_CLK_MSK:  rdata = {m_clk, m_ref};
            A_CH_MSK:   rdata = {m_ch, 1'b0};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/alm_irq_ctrl.sv
// Top of the alarm controller. It watches NCH transmit clocks and one
// reference clock, merges the reference loss into every channel's loss of
// signal, and drives a registered interrupt from the unmasked alarms.
// Assumes los_in is already synchronous to clk.
module alm_irq_ctrl
    import alm_pkg::*;
#(
    parameter int NCH      = 7,
    parameter int LOSS_CYC = 8,
    parameter int HOLD_CYC = 6300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tx_clk_in,
    input  logic              ref_clk_in,
    input  logic [NCH-1:0]    los_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NCH:0]      reg_wdata,
    output logic [NCH:0]      reg_rdata,
    output logic              irq,
    output logic [NCH-1:0]    los_pin,
    output logic [NCH-1:0]    tx_zero,
    output logic              rx_keep
);
    logic [NCH-1:0] txc_alarm;
    logic           ref_alarm;
    logic [NCH-1:0] los_eff;
    logic [NCH-1:0] m_los, m_clk, m_ch;
    logic           m_ref;
    logic           irq_next;
    logic           irq_q;

    // One monitor per transmit clock.
    for (genvar g = 0; g < NCH; g++) begin : g_txmon
        alm_clk_mon #(.LOSS_CYC(LOSS_CYC), .HOLD_CYC(HOLD_CYC)) mon_i (
            .clk(clk), .rst_n(rst_n), .mon_clk(tx_clk_in[g]), .alarm(txc_alarm[g])
        );
    end

    alm_clk_mon #(.LOSS_CYC(LOSS_CYC), .HOLD_CYC(HOLD_CYC)) ref_mon_i (
        .clk(clk), .rst_n(rst_n), .mon_clk(ref_clk_in), .alarm(ref_alarm)
    );

    assign los_eff = los_in | {NCH{ref_alarm}};
    assign los_pin = los_eff;
    assign tx_zero = txc_alarm;

    alm_regs #(.NCH(NCH)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .los_stat(los_eff), .clk_stat(txc_alarm), .ref_stat(ref_alarm),
        .rdata(reg_rdata), .m_los(m_los), .m_clk(m_clk), .m_ref(m_ref),
        .m_ch(m_ch), .rx_keep(rx_keep)
    );

    // Combine every alarm with its masks.
    always_comb begin
        irq_next = (ref_alarm && !m_ref)
                || (|(los_eff & ~m_los & ~m_ch))
                || (|(txc_alarm & ~m_clk & ~m_ch));
    end

    // Register the interrupt so mask writes cannot glitch it.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_next;
    end

    assign irq = irq_q;
endmodule

// File: rtl/alm_irq_ctrl_chk.sv
// Assertion checker for alm_irq_ctrl, bound to every instance of it.
module alm_irq_ctrl_chk #(
    parameter int NCH      = 7,
    parameter int HOLD_CYC = 6300
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2:0]     reg_addr,
    input logic [NCH:0]   reg_rdata,
    input logic           irq,
    input logic [NCH-1:0] los_pin,
    input logic [NCH-1:0] txc_alarm,
    input logic           ref_alarm,
    input logic [NCH-1:0] m_los,
    input logic [NCH-1:0] m_clk,
    input logic [NCH-1:0] m_ch,
    input logic           m_ref,
    input logic           rx_keep
);
    logic          any_open;
    logic [NCH:0]  alm_vec;
    int unsigned   run_cnt [NCH+1];

    assign any_open = (ref_alarm && !m_ref)
                   || ((los_pin & ~m_ch & ~m_los) != '0)
                   || ((txc_alarm & ~m_ch & ~m_clk) != '0);
    assign alm_vec  = {txc_alarm, ref_alarm};

    // R1 and R6: the interrupt equals the previous cycle's unmasked alarm state.
    p_irq_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(any_open));

    // R2: the masks come out of reset all set.
    p_mask_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (m_los == '1 && m_clk == '1 && m_ch == '1 && m_ref && !rx_keep));

    // R3: loss-of-signal status reads back equal to the pins.
    p_los_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> (reg_rdata == {los_pin, 1'b0}));

    // R5: reference loss drives every loss-of-signal pin.
    p_ref_los_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_alarm |-> (los_pin == '1));

    // R4: each clock-loss alarm stays high for at least the hold time.
    for (genvar k = 0; k <= NCH; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n || !alm_vec[k]) run_cnt[k] <= 0;
            else                       run_cnt[k] <= run_cnt[k] + 1;
        end
        p_hold_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(alm_vec[k]) |-> (run_cnt[k] >= HOLD_CYC));
    end
endmodule

bind alm_irq_ctrl alm_irq_ctrl_chk #(.NCH(NCH), .HOLD_CYC(HOLD_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .irq(irq), .los_pin(los_pin), .txc_alarm(txc_alarm), .ref_alarm(ref_alarm),
    .m_los(m_los), .m_clk(m_clk), .m_ch(m_ch), .m_ref(m_ref), .rx_keep(rx_keep)
);

// File: tb/alm_irq_ctrl_tb_top.sv
// Self-checking bench for alm_irq_ctrl, with a shortened hold time.
module alm_irq_ctrl_tb_top;
    localparam int NCH  = 7;
    localparam int HOLD = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] tx_clk_in = '0;
    logic           ref_clk_in = 1'b0;
    logic [NCH-1:0] los_in = '0;
    logic [2:0]     reg_addr = '0;
    logic           reg_wr = 1'b0;
    logic [NCH:0]   reg_wdata = '0;
    logic [NCH:0]   reg_rdata;
    logic           irq;
    logic [NCH-1:0] los_pin, tx_zero;
    logic           rx_keep;

    logic [NCH-1:0] tx_run = '1;
    logic           ref_run = 1'b1;
    int             nvec = 0;
    int             nbad = 0;

    alm_irq_ctrl #(.NCH(NCH), .LOSS_CYC(8), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_clk_in(tx_clk_in), .ref_clk_in(ref_clk_in),
        .los_in(los_in), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .los_pin(los_pin), .tx_zero(tx_zero),
        .rx_keep(rx_keep)
    );

    always #10 clk = ~clk;

    // Watched clocks toggle every two detection cycles while enabled.
    initial begin
        bit ph = 1'b0;
        forever begin
            @(negedge clk);
            ph = !ph;
            if (ph) begin
                tx_clk_in = tx_clk_in ^ tx_run;
                if (ref_run) ref_clk_in = !ref_clk_in;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [NCH:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [NCH:0] exp);
        reg_addr = a;
        #2;
        chk(req, int'(reg_rdata), int'(exp));
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [NCH:0] bit_m;
        waitn(3);
        rst_n = 1'b1;
        waitn(20);
        // R2: reset state.
        rd_chk("R2 addr2", 3'd2, 8'hFE);
        rd_chk("R2 addr3", 3'd3, 8'hFF);
        rd_chk("R2 addr4", 3'd4, 8'hFE);
        chk("R2 irq", int'(irq), 0);
        rd_chk("R10 addr0 idle", 3'd0, 8'h00);
        rd_chk("R10 addr1 idle", 3'd1, 8'h00);

        // R1 R3 R6 R10: loss of signal per channel, all mask combinations.
        for (int i = 0; i < NCH; i++) begin
            for (int m = 0; m < 4; m++) begin
                bit_m = 8'(1) << (i + 1);
                wr_reg(3'd2, m[0] ? 8'hFE : (8'hFE & ~bit_m));
                wr_reg(3'd4, m[1] ? 8'hFE : (8'hFE & ~bit_m));
                los_in = NCH'(1) << i;
                waitn(2);
                chk("R1/R6 irq los", int'(irq), int'(!m[0] && !m[1]));
                rd_chk("R3/R10 los status", 3'd0, bit_m);
                chk("R3 los_pin", int'(los_pin), int'(NCH'(1) << i));
                los_in = '0;
                waitn(2);
                chk("R1 irq cleared", int'(irq), 0);
            end
        end
        wr_reg(3'd2, 8'hFE);
        wr_reg(3'd4, 8'hFE);

        // R1: the interrupt is registered one cycle behind a mask write.
        los_in = 7'h01;
        wr_reg(3'd4, 8'hFC);
        wr_reg(3'd2, 8'hFC);
        chk("R1 irq not yet", int'(irq), 0);
        waitn(1);
        chk("R1 irq next cycle", int'(irq), 1);
        wr_reg(3'd2, 8'hFE);
        chk("R1 irq still up", int'(irq), 1);
        waitn(1);
        chk("R1 irq dropped", int'(irq), 0);
        los_in = '0;
        wr_reg(3'd4, 8'hFE);

        // R4 R6 R7 R10: transmit clock loss per channel.
        for (int i = 0; i < NCH; i++) begin
            bit_m = 8'(1) << (i + 1);
            wr_reg(3'd3, 8'hFF & ~bit_m);
            wr_reg(3'd4, 8'hFE & ~bit_m);
            tx_run[i] = 1'b0;
            waitn(20);
            rd_chk("R4/R10 txc status", 3'd1, bit_m);
            chk("R7 tx_zero", int'(tx_zero), int'(NCH'(1) << i));
            chk("R1 irq txc", int'(irq), 1);
            wr_reg(3'd4, 8'hFE);
            waitn(1);
            chk("R6 chan mask txc", int'(irq), 0);
            rd_chk("R3 status under mask", 3'd1, bit_m);
            tx_run[i] = 1'b1;
            waitn(10);
            rd_chk("R4 held", 3'd1, bit_m);
            waitn(HOLD + 20);
            rd_chk("R4 cleared", 3'd1, 8'h00);
            chk("R7 tx_zero cleared", int'(tx_zero), 0);
            wr_reg(3'd3, 8'hFF);
        end

        // R5: reference loss.
        ref_run = 1'b0;
        waitn(20);
        rd_chk("R5 ref bit", 3'd1, 8'h01);
        rd_chk("R5 los bits", 3'd0, 8'hFE);
        chk("R5 los_pin", int'(los_pin), 'h7F);
        chk("R1 irq masked", int'(irq), 0);
        wr_reg(3'd3, 8'hFE);
        waitn(1);
        chk("R1 irq ref", int'(irq), 1);
        ref_run = 1'b1;
        waitn(10);
        rd_chk("R4 ref held", 3'd1, 8'h01);
        waitn(HOLD + 20);
        rd_chk("R4 ref cleared", 3'd1, 8'h00);
        rd_chk("R5 los cleared", 3'd0, 8'h00);
        chk("R1 irq ref gone", int'(irq), 0);
        wr_reg(3'd3, 8'hFF);

        // R8: status addresses ignore writes.
        wr_reg(3'd0, 8'hFF);
        wr_reg(3'd1, 8'hFF);
        rd_chk("R8 addr0", 3'd0, 8'h00);
        rd_chk("R8 addr1", 3'd1, 8'h00);
        rd_chk("R8 masks kept", 3'd2, 8'hFE);
        rd_chk("R8 masks kept 3", 3'd3, 8'hFF);

        // R9: rx_keep control bit.
        wr_reg(3'd2, 8'hFF);
        chk("R9 rx_keep set", int'(rx_keep), 1);
        rd_chk("R9 readback", 3'd2, 8'hFF);
        wr_reg(3'd2, 8'hFE);
        chk("R9 rx_keep clear", int'(rx_keep), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule